// File: doc/BRIEF.md
# Local Interrupt Controller Register File

This block holds the software-visible configuration registers of a local interrupt controller. Software reaches it through a simple request port that carries a byte offset, an access size of one to four bytes, a write flag and write data. Every request gets a response one cycle later with read data and an error flag. Registers sit on 16-byte boundaries. The low three offset bits select a byte lane inside an 8-byte slot and play no part in the decode.

Each register applies its own write rule. Some registers keep only a field of the written value. One register forces its low bits to one. The vector table entries protect their status bits from writes. The version and current-count registers cannot be written. Error status is cleared by a two-write handshake: the first write arms an internal flag, the second write clears the register, and any read disarms the flag. A write to the end-of-interrupt location stores nothing and raises a one-cycle strobe for the priority logic. Bit 8 of the spurious-vector register drives the software-enable output. Task priority, initial count and divide configuration are also brought out to their consumers.

Top module: `lic_regfile`

## Requirements
- R1: A request whose offset, with bits [2:0] cleared, is not one of 0x020, 0x030, 0x080, 0x0B0, 0x0D0, 0x0E0, 0x0F0, 0x280, 0x320, 0x330, 0x340, 0x350, 0x360, 0x370, 0x380, 0x390 or 0x3E0 returns rsp_err=1 and rsp_rdata=0. A mapped, non-spanning request returns rsp_err=0.
- R2: An access spans two slots when offset[2:0] + req_size exceeds 7, where req_size is the byte count minus one. Such an access returns rsp_err=1 and rsp_rdata=0, and no register changes.
- R3: A read returns the 32-bit register value shifted right by 8*offset[2:0], so lanes 4 to 7 read as zero. A write replaces only the req_size+1 register bytes starting at lane offset[2:0], taking them from the low bytes of req_wdata. The register's write rule is then applied to the merged value.
- R4: The ID register (0x020) and the task-priority register (0x080) keep only bits [7:0] of a write, and task_prio shows the stored priority. The logical-destination register (0x0D0) keeps only bits [31:24].
- R5: A write to destination format (0x0E0) stores its bits [31:28] and forces bits [27:0] to 1.
- R6: The version register (0x030) always reads the VERSION parameter. The current-count register (0x390) always reads the cur_count_i input. Writes to either change nothing and are not errors.
- R7: In each of the six vector-table entries (0x320 to 0x370), bits 12 and 14 keep their old value on a write. All other bits take the written value.
- R8: Bits set on err_events are OR-ed into error status (0x280). The first write to error status only arms an internal flag. A write while the flag is armed clears the register and disarms the flag. Any read of error status disarms the flag.
- R9: Bit 8 of the value written to the spurious-vector register (0x0F0) appears on sw_enable from the cycle after the write. The output changes on no other request.
- R10: A non-spanning write to 0x0B0 pulses eoi_pulse high for exactly one cycle, in the cycle after the request. Reading 0x0B0 returns 0 with no error.
- R11: rsp_valid is high exactly in the cycle after each cycle in which req_valid is high.
- R12: After reset the registers are: ID, task priority, logical destination, error status, initial count and divide configuration 0; destination format 0xFFFFFFFF; spurious vector 0x000000FF; each vector-table entry 0x00010000. sw_enable, rsp_valid and eoi_pulse are low.
- R13: Divide configuration (0x3E0) keeps only bits 0, 1 and 3 of a write, and divide_cfg shows the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | DATA_W | Write data, low byte first |
| err_events | input | ERR_W | Error bits to set in error status |
| cur_count_i | input | DATA_W | Current count supplied by the timer |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Unmapped or slot-spanning access |
| rsp_rdata | output | DATA_W | Read data |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| sw_enable | output | 1 | Software-enable state |
| task_prio | output | 8 | Stored task priority |
| init_count | output | DATA_W | Stored initial count |
| divide_cfg | output | 4 | Stored divide configuration |

## Verification
The assertions check the following on every cycle: a response follows every request and only a request, a spanning access always answers with an error and zero data, every error response carries zero data, the end-of-interrupt strobe appears exactly when a clean end-of-interrupt write came in the cycle before, and sw_enable moves only after a spurious-vector write. Other behaviour needs the bench's scenarios: the per-register write masks, the protected vector-table bits, lane merging for partial writes, the arm, disarm and clear sequence of error status, and the reset value of every mapped register across a full offset sweep.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_VER, SEL_TPR, SEL_EOI, SEL_LDR, SEL_DFR,
    SEL_SVR, SEL_ESR, SEL_LVT, SEL_ICNT, SEL_CCNT, SEL_DCFG
  } reg_sel_e;

  localparam logic [15:0] OFS_ID   = 16'h0020;
  localparam logic [15:0] OFS_VER  = 16'h0030;
  localparam logic [15:0] OFS_TPR  = 16'h0080;
  localparam logic [15:0] OFS_EOI  = 16'h00B0;
  localparam logic [15:0] OFS_LDR  = 16'h00D0;
  localparam logic [15:0] OFS_DFR  = 16'h00E0;
  localparam logic [15:0] OFS_SVR  = 16'h00F0;
  localparam logic [15:0] OFS_ESR  = 16'h0280;
  localparam logic [15:0] OFS_LVT0 = 16'h0320;
  localparam logic [15:0] OFS_ICNT = 16'h0380;
  localparam logic [15:0] OFS_CCNT = 16'h0390;
  localparam logic [15:0] OFS_DCFG = 16'h03E0;
  localparam int          REG_STRIDE = 16;

  localparam logic [31:0] LVT_RO_MASK = 32'h0000_5000;
  localparam logic [31:0] LVT_RST     = 32'h0001_0000;
  localparam logic [31:0] SVR_RST     = 32'h0000_00FF;
  localparam logic [3:0]  DCFG_MASK   = 4'hB;
  localparam int          SWEN_BIT    = 8;

endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_LVT  = 6,
  localparam int IDX_W = (N_LVT > 1) ? $clog2(N_LVT) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  lvt_idx,
  output logic              span
);

  localparam logic [15:0] LVT_LAST = OFS_LVT0 + 16'(REG_STRIDE * (N_LVT - 1));

  logic [15:0] slot_addr;

  always_comb begin
    slot_addr = 16'(addr) & 16'hFFF8;
    sel       = SEL_NONE;
    lvt_idx   = '0;
    unique case (slot_addr)
      OFS_ID:   sel = SEL_ID;
      OFS_VER:  sel = SEL_VER;
      OFS_TPR:  sel = SEL_TPR;
      OFS_EOI:  sel = SEL_EOI;
      OFS_LDR:  sel = SEL_LDR;
      OFS_DFR:  sel = SEL_DFR;
      OFS_SVR:  sel = SEL_SVR;
      OFS_ESR:  sel = SEL_ESR;
      OFS_ICNT: sel = SEL_ICNT;
      OFS_CCNT: sel = SEL_CCNT;
      OFS_DCFG: sel = SEL_DCFG;
      default: begin
        if (slot_addr >= OFS_LVT0 && slot_addr <= LVT_LAST && !slot_addr[3]) begin
          sel     = SEL_LVT;
          lvt_idx = IDX_W'((slot_addr - OFS_LVT0) >> 4);
        end
      end
    endcase
  end

  // the last byte lies past the 8-byte slot when offset + (bytes-1) >= 8
  assign span = 4'({1'b0, addr[2:0]} + {2'b00, size}) > 4'd7;

endmodule

// File: rtl/lic_lanes.sv
module lic_lanes #(
  parameter int DATA_W = 32,
  localparam int SLOT_W = 64,
  localparam int SLOT_B = SLOT_W / 8
) (
  input  logic [2:0]        off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd_val
);

  logic [SLOT_W-1:0] old_slot;
  logic [SLOT_W-1:0] wd_slot;
  logic [SLOT_B-1:0] byte_en;
  logic [SLOT_W-1:0] bit_en;
  logic [3:0]        nbytes;

  assign nbytes   = {2'b00, size} + 4'd1;
  assign old_slot = SLOT_W'(old_val);
  assign wd_slot  = SLOT_W'(wdata) << {off, 3'b000};
  assign byte_en  = SLOT_B'(((SLOT_B+1)'(1) << nbytes) - (SLOT_B+1)'(1)) << off;

  for (genvar b = 0; b < SLOT_B; b++) begin : g_be
    assign bit_en[8*b +: 8] = {8{byte_en[b]}};
  end

  assign merged = DATA_W'((old_slot & ~bit_en) | (wd_slot & bit_en));
  assign rd_val = DATA_W'(old_slot >> {off, 3'b000});

endmodule

// File: rtl/lic_store.sv
module lic_store
  import lic_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          N_LVT   = 6,
  parameter int          ERR_W   = 8,
  parameter logic [31:0] VERSION = 32'h0005_0014,
  localparam int IDX_W = (N_LVT > 1) ? $clog2(N_LVT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              esr_rd,
  input  reg_sel_e          sel,
  input  logic [IDX_W-1:0]  lvt_idx,
  input  logic [DATA_W-1:0] wval,
  input  logic [ERR_W-1:0]  err_events,
  input  logic [DATA_W-1:0] cur_count_i,
  output logic [DATA_W-1:0] cur_val,
  output logic              sw_enable,
  output logic [7:0]        task_prio,
  output logic [DATA_W-1:0] init_count,
  output logic [3:0]        divide_cfg
);

  logic [7:0]        id_q;
  logic [7:0]        tpr_q;
  logic [7:0]        ldr_q;
  logic [3:0]        dfr_q;
  logic [DATA_W-1:0] svr_q;
  logic [DATA_W-1:0] esr_q;
  logic              esr_armed_q;
  logic              swen_q;
  logic [DATA_W-1:0] icnt_q;
  logic [3:0]        dcfg_q;
  logic [DATA_W-1:0] lvt_q [N_LVT];

  logic wr_esr;
  logic esr_clear;
  assign wr_esr    = wr_en && (sel == SEL_ESR);
  assign esr_clear = wr_esr && esr_armed_q;

  // plain field registers
  always_ff @(posedge clk) begin
    if (rst) begin
      id_q   <= '0;
      tpr_q  <= '0;
      ldr_q  <= '0;
      dfr_q  <= 4'hF;
      svr_q  <= DATA_W'(SVR_RST);
      swen_q <= 1'b0;
      icnt_q <= '0;
      dcfg_q <= '0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_ID:   id_q   <= wval[7:0];
        SEL_TPR:  tpr_q  <= wval[7:0];
        SEL_LDR:  ldr_q  <= wval[31:24];
        SEL_DFR:  dfr_q  <= wval[31:28];
        SEL_SVR: begin
          svr_q  <= wval;
          swen_q <= wval[SWEN_BIT];
        end
        SEL_ICNT: icnt_q <= wval;
        SEL_DCFG: dcfg_q <= wval[3:0] & DCFG_MASK;
        default: ;
      endcase
    end
  end

  // vector table entries with protected status bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < N_LVT; i++) begin
      if (rst) begin
        lvt_q[i] <= DATA_W'(LVT_RST);
      end else if (wr_en && sel == SEL_LVT && lvt_idx == IDX_W'(i)) begin
        lvt_q[i] <= (wval & ~DATA_W'(LVT_RO_MASK)) | (lvt_q[i] & DATA_W'(LVT_RO_MASK));
      end
    end
  end

  // error status with arm-then-clear handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      esr_q       <= '0;
      esr_armed_q <= 1'b0;
    end else begin
      esr_q <= (esr_clear ? '0 : esr_q) | DATA_W'(err_events);
      if (wr_esr)      esr_armed_q <= !esr_armed_q;
      else if (esr_rd) esr_armed_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ID:   cur_val = DATA_W'(id_q);
      SEL_VER:  cur_val = DATA_W'(VERSION);
      SEL_TPR:  cur_val = DATA_W'(tpr_q);
      SEL_LDR:  cur_val = {ldr_q, 24'h000000};
      SEL_DFR:  cur_val = {dfr_q, 28'hFFF_FFFF};
      SEL_SVR:  cur_val = svr_q;
      SEL_ESR:  cur_val = esr_q;
      SEL_LVT:  cur_val = lvt_q[lvt_idx];
      SEL_ICNT: cur_val = icnt_q;
      SEL_CCNT: cur_val = cur_count_i;
      SEL_DCFG: cur_val = DATA_W'(dcfg_q);
      default:  cur_val = '0;
    endcase
  end

  assign sw_enable  = swen_q;
  assign task_prio  = tpr_q;
  assign init_count = icnt_q;
  assign divide_cfg = dcfg_q;

endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          N_LVT   = 6,
  parameter int          ERR_W   = 8,
  parameter logic [31:0] VERSION = 32'h0005_0014,
  localparam int IDX_W = (N_LVT > 1) ? $clog2(N_LVT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [ERR_W-1:0]  err_events,
  input  logic [DATA_W-1:0] cur_count_i,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              eoi_pulse,
  output logic              sw_enable,
  output logic [7:0]        task_prio,
  output logic [DATA_W-1:0] init_count,
  output logic [3:0]        divide_cfg
);

  reg_sel_e          sel;
  logic [IDX_W-1:0]  lvt_idx;
  logic              span;
  logic [DATA_W-1:0] cur_val;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] rd_val;
  logic              bad;
  logic              wr_ok;
  logic              rd_ok;

  lic_decode #(.ADDR_W(ADDR_W), .N_LVT(N_LVT)) u_decode (
    .addr    (req_addr),
    .size    (req_size),
    .sel     (sel),
    .lvt_idx (lvt_idx),
    .span    (span)
  );

  lic_lanes #(.DATA_W(DATA_W)) u_lanes (
    .off     (req_addr[2:0]),
    .size    (req_size),
    .old_val (cur_val),
    .wdata   (req_wdata),
    .merged  (merged),
    .rd_val  (rd_val)
  );

  assign bad   = span || (sel == SEL_NONE);
  assign wr_ok = req_valid && req_write && !bad;
  assign rd_ok = req_valid && !req_write && !bad;

  lic_store #(
    .DATA_W (DATA_W),
    .N_LVT  (N_LVT),
    .ERR_W  (ERR_W),
    .VERSION(VERSION)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_ok),
    .esr_rd     (rd_ok && sel == SEL_ESR),
    .sel        (sel),
    .lvt_idx    (lvt_idx),
    .wval       (merged),
    .err_events (err_events),
    .cur_count_i(cur_count_i),
    .cur_val    (cur_val),
    .sw_enable  (sw_enable),
    .task_prio  (task_prio),
    .init_count (init_count),
    .divide_cfg (divide_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      eoi_pulse <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= rd_ok ? rd_val : '0;
      eoi_pulse <= wr_ok && (sel == SEL_EOI);
    end
  end

endmodule

// File: rtl/lic_regfile_chk.sv
module lic_regfile_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              eoi_pulse,
  input logic              sw_enable
);

  logic [15:0] slot_c;
  logic        span_c;
  logic        eoi_wr_c;
  logic        svr_wr_c;

  assign slot_c   = 16'({req_addr[ADDR_W-1:3], 3'b000});
  assign span_c   = (int'(req_addr[2:0]) + int'(req_size)) >= 8;
  assign eoi_wr_c = req_valid && req_write && !span_c && slot_c == 16'h00B0;
  assign svr_wr_c = req_valid && req_write && !span_c && slot_c == 16'h00F0;

  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r11_no_extra_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r2_span_errors: assert property (@(posedge clk) disable iff (rst)
    (req_valid && span_c) |=> (rsp_err && rsp_rdata == '0));

  a_r1_err_zero_data: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_rdata == '0);

  a_r10_eoi_fires: assert property (@(posedge clk) disable iff (rst)
    eoi_wr_c |=> eoi_pulse);

  a_r10_eoi_cause: assert property (@(posedge clk) disable iff (rst)
    !eoi_wr_c |=> !eoi_pulse);

  a_r9_swen_hold: assert property (@(posedge clk) disable iff (rst)
    !svr_wr_c |=> $stable(sw_enable));

endmodule

bind lic_regfile lic_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_size (req_size),
  .rsp_valid(rsp_valid),
  .rsp_err  (rsp_err),
  .rsp_rdata(rsp_rdata),
  .eoi_pulse(eoi_pulse),
  .sw_enable(sw_enable)
);

// File: tb/tb_lic_regfile.sv
module tb_lic_regfile;

  localparam logic [31:0] VER = 32'h0005_0014;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  err_events = '0;
  logic [31:0] cur_count_i = 32'h1234_5678;
  logic        rsp_valid, rsp_err, eoi_pulse, sw_enable;
  logic [31:0] rsp_rdata, init_count;
  logic [7:0]  task_prio;
  logic [3:0]  divide_cfg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] r_data;
  logic        r_err, r_valid, r_eoi;

  always #10 clk = ~clk;

  lic_regfile #(.ADDR_W(12), .DATA_W(32), .N_LVT(6), .ERR_W(8), .VERSION(VER)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .err_events(err_events), .cur_count_i(cur_count_i),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .eoi_pulse(eoi_pulse), .sw_enable(sw_enable), .task_prio(task_prio),
    .init_count(init_count), .divide_cfg(divide_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input int addr, input int sz, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = 12'(addr);
    req_size  = 2'(sz);
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
    r_data  = rsp_rdata;
    r_err   = rsp_err;
    r_valid = rsp_valid;
    r_eoi   = eoi_pulse;
  endtask

  task automatic rd_chk(input string tag, input int addr, input logic [31:0] exp);
    acc(0, addr, 3, 32'h0);
    chk({tag, " err"}, {31'b0, r_err}, 32'h0);
    chk({tag, " data"}, r_data, exp);
  endtask

  function automatic bit reset_val(input int a, output logic [31:0] v);
    v = 32'h0;
    case (a)
      'h020, 'h080, 'h0B0, 'h0D0, 'h280, 'h380, 'h3E0: return 1;
      'h030: begin v = VER; return 1; end
      'h0E0: begin v = 32'hFFFF_FFFF; return 1; end
      'h0F0: begin v = 32'h0000_00FF; return 1; end
      'h390: begin v = cur_count_i; return 1; end
      'h320, 'h330, 'h340, 'h350, 'h360, 'h370: begin v = 32'h0001_0000; return 1; end
      default: return 0;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ev;
    bit          mp;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 outputs after reset
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R12 eoi_pulse", {31'b0, eoi_pulse}, 32'h0);
    chk("R12 sw_enable", {31'b0, sw_enable}, 32'h0);
    chk("R12 task_prio", {24'b0, task_prio}, 32'h0);
    chk("R12 divide_cfg", {28'b0, divide_cfg}, 32'h0);
    chk("R12 init_count", init_count, 32'h0);

    // R1 / R12 full offset sweep
    for (int a = 0; a < 4096; a += 8) begin
      mp = reset_val(a, ev);
      acc(0, a, 3, 32'h0);
      chk($sformatf("R1 err @%h", a), {31'b0, r_err}, {31'b0, !mp});
      chk($sformatf("R12 data @%h", a), r_data, mp ? ev : 32'h0);
    end
    // R1: offset with bit 3 set is unmapped
    acc(0, 'h028, 3, 0);
    chk("R1 0x028 err", {31'b0, r_err}, 32'h1);

    // R11 response timing
    acc(0, 'h020, 3, 0);
    chk("R11 valid", {31'b0, r_valid}, 32'h1);
    @(negedge clk);
    chk("R11 idle", {31'b0, rsp_valid}, 32'h0);

    // R4
    acc(1, 'h020, 3, 32'hAABB_CCDD); rd_chk("R4 id", 'h020, 32'h0000_00DD);
    acc(1, 'h080, 3, 32'h0000_0123); rd_chk("R4 tpr", 'h080, 32'h0000_0023);
    chk("R4 task_prio", {24'b0, task_prio}, 32'h23);
    acc(1, 'h0D0, 3, 32'h1234_5678); rd_chk("R4 ldr", 'h0D0, 32'h1200_0000);

    // R5
    acc(1, 'h0E0, 3, 32'h0); rd_chk("R5 dfr0", 'h0E0, 32'h0FFF_FFFF);
    acc(1, 'h0E0, 3, 32'hA000_0001); rd_chk("R5 dfrA", 'h0E0, 32'hAFFF_FFFF);

    // R6
    acc(1, 'h030, 3, 32'h0);
    chk("R6 ver wr err", {31'b0, r_err}, 32'h0);
    rd_chk("R6 ver", 'h030, VER);
    acc(1, 'h390, 3, 32'hDEAD_BEEF);
    cur_count_i = 32'h0000_0777;
    rd_chk("R6 ccnt", 'h390, 32'h0000_0777);

    // R7 each vector table entry
    for (int i = 0; i < 6; i++) begin
      acc(1, 'h320 + 16 * i, 3, 32'hFFFF_FFFF);
      rd_chk($sformatf("R7 lvt%0d ones", i), 'h320 + 16 * i, 32'hFFFF_AFFF);
      acc(1, 'h320 + 16 * i, 3, 32'h0000_0000);
      rd_chk($sformatf("R7 lvt%0d zero", i), 'h320 + 16 * i, 32'h0000_0000);
    end

    // R13
    acc(1, 'h3E0, 3, 32'hFFFF_FFFF); rd_chk("R13 dcfg", 'h3E0, 32'h0000_000B);
    chk("R13 divide_cfg", {28'b0, divide_cfg}, 32'hB);
    acc(1, 'h3E0, 3, 32'h0000_0004); rd_chk("R13 dcfg bit2", 'h3E0, 32'h0);

    // R3 lane handling on initial count
    acc(1, 'h380, 3, 32'h1122_3344);
    chk("R3 init_count", init_count, 32'h1122_3344);
    acc(1, 'h381, 0, 32'h0000_00EE); rd_chk("R3 byte wr", 'h380, 32'h1122_EE44);
    acc(0, 'h382, 1, 0); chk("R3 half rd", r_data, 32'h0000_1122);
    acc(0, 'h384, 3, 0); chk("R3 upper lanes", r_data, 32'h0);
    acc(1, 'h382, 1, 32'h0000_5566); rd_chk("R3 half wr", 'h380, 32'h5566_EE44);
    acc(1, 'h384, 3, 32'hFFFF_FFFF); rd_chk("R3 upper wr", 'h380, 32'h5566_EE44);

    // R2 spanning accesses
    acc(1, 'h385, 3, 32'h0);
    chk("R2 wr err", {31'b0, r_err}, 32'h1);
    rd_chk("R2 no update", 'h380, 32'h5566_EE44);
    acc(0, 'h386, 2, 0);
    chk("R2 rd err", {31'b0, r_err}, 32'h1);
    chk("R2 rd data", r_data, 32'h0);
    acc(0, 'h387, 0, 0);
    chk("R2 last byte ok", {31'b0, r_err}, 32'h0);

    // R9
    acc(1, 'h0F0, 3, 32'h0000_01FF);
    chk("R9 swen on", {31'b0, sw_enable}, 32'h1);
    rd_chk("R9 svr", 'h0F0, 32'h0000_01FF);
    acc(1, 'h0F7, 3, 32'h0);
    chk("R9 span keeps", {31'b0, sw_enable}, 32'h1);
    acc(1, 'h0F0, 3, 32'h0000_00FF);
    chk("R9 swen off", {31'b0, sw_enable}, 32'h0);

    // R10
    acc(1, 'h0B0, 3, 32'hFFFF_FFFF);
    chk("R10 pulse", {31'b0, r_eoi}, 32'h1);
    @(negedge clk);
    chk("R10 one cycle", {31'b0, eoi_pulse}, 32'h0);
    rd_chk("R10 eoi read", 'h0B0, 32'h0);
    acc(1, 'h0B6, 3, 32'h0);
    chk("R10 span no pulse", {31'b0, r_eoi}, 32'h0);

    // R8 error status handshake
    @(negedge clk); err_events = 8'h05;
    @(negedge clk); err_events = 8'h00;
    rd_chk("R8 set", 'h280, 32'h0000_0005);
    acc(1, 'h280, 3, 32'h0);
    rd_chk("R8 arm keeps", 'h280, 32'h0000_0005);
    acc(1, 'h280, 3, 32'h0);
    rd_chk("R8 read disarmed", 'h280, 32'h0000_0005);
    acc(1, 'h280, 3, 32'h0);
    acc(1, 'h280, 3, 32'h0);
    rd_chk("R8 cleared", 'h280, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule